// File: doc/BRIEF.md
# Quota-Weighted Packet Splitter

This block steers a single incoming stream of sized packets across a configurable number of output ports. Each port has a static quota, measured as an amount of payload rather than a number of packets. Over time, each port receives a share of the traffic in proportion to its quota. The block stores no packets. Each packet is offered to exactly one output in the same cycle it appears at the input, and the input and outputs use valid/ready handshakes.

Every port keeps a running tally of the payload it has accepted. A port stops taking traffic once its tally reaches its quota. A packet skips any port that has stopped and goes to the next open port in fixed priority order, with port 0 first. The tallies of all ports are cleared together, in the same cycle as the transfer that closes the last open port. The next packet therefore starts a fresh round at port 0. Any amount by which the last packet overshot its port's quota is not carried into the next round.

Top module: `qsplit_top`

## Requirements
- R1: At most one output valid is high in any cycle. It is the lowest-indexed port whose tally is below its quota.
- R2: A port adds each accepted packet's size to its tally, which saturates at 2^W-1 instead of wrapping. The port stops receiving once its tally is greater than or equal to its quota.
- R3: A packet offered while higher-priority ports have stopped goes to the next open port in index order. It is neither stalled nor dropped.
- R4: The transfer that closes the last open port also clears every tally in the same cycle. The following packet goes to the lowest-indexed port with a nonzero quota, and overshoot from the previous round is discarded.
- R5: A port whose quota is zero never asserts its output valid.
- R6: When every quota is zero, inReady stays low and no output valid is asserted.
- R7: When the selected port has its ready low, inReady is low, the packet is not redirected to another port, and no tally changes.
- R8: outSize always equals inSize. No output valid is asserted while inValid is low.
- R9: After a synchronous active-high reset, all tallies are zero, so every port with a nonzero quota is open.
- R10: Over a whole round with unit-size packets, the count delivered to each port equals its quota.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quota | input | N*W | Per-port quotas, port i in bits [i*W +: W] |
| inValid | input | 1 | Input packet present |
| inReady | output | 1 | Input packet accepted this cycle |
| inSize | input | W | Size of the input packet |
| outValid | output | N | One-hot valid toward the chosen port |
| outReady | input | N | Per-port ready |
| outSize | output | W | Size presented to the chosen port |

## Verification
Two actions can fall in the same clock edge: a port accepting a packet and adding to its tally, and the clear of all tallies. They coincide whenever the accepted packet closes the last open port. The bench provokes this coincidence by sending rounds whose final packet overshoots the quota and by sending a run of unit packets through several complete rounds. It judges the result by whether the packet that follows each round is routed to port 0, which would not happen if the clear were lost, delayed by a cycle, or applied before the tally update.

// File: rtl/qsplit_pkg.sv
package qsplit_pkg;
  typedef struct packed {
    logic take;   // a packet moves this cycle
    logic wipe;   // all tallies return to zero this cycle
  } strobe_t;
endpackage

// File: rtl/qsplit_tally.sv
module qsplit_tally
  import qsplit_pkg::*;
#(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  strobe_t        strb,
  input  logic [N-1:0]   grant,
  input  logic [W-1:0]   inSize,
  input  logic [N*W-1:0] quota,
  output logic [N-1:0]   closed,
  output logic           closeAll,
  output logic [N*W-1:0] totalsFlat
);
  logic [N-1:0] closedAfter;

  for (genvar i = 0; i < N; i++) begin : g_port
    logic [W-1:0] tally;
    logic [W:0]   rawSum;
    logic [W-1:0] satSum;
    logic [W-1:0] limit;

    assign limit  = quota[i*W +: W];
    assign rawSum = {1'b0, tally} + {1'b0, inSize};
    assign satSum = rawSum[W] ? {W{1'b1}} : rawSum[W-1:0];

    assign closed[i]      = (tally >= limit);
    assign closedAfter[i] = closed[i] | (grant[i] & (satSum >= limit));
    assign totalsFlat[i*W +: W] = tally;

    always_ff @(posedge clk) begin
      if (rst || strb.wipe) tally <= '0;
      else if (strb.take && grant[i]) tally <= satSum;
    end
  end

  // AND of all closed flags, formed as the inverse of the OR of their inverses
  assign closeAll = ~|(~closedAfter);
endmodule

// File: rtl/qsplit_ctrl.sv
module qsplit_ctrl
  import qsplit_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         inValid,
  input  logic [N-1:0] closed,
  input  logic [N-1:0] outReady,
  input  logic         closeAll,
  output logic [N-1:0] grant,
  output logic [N-1:0] outValid,
  output logic         inReady,
  output strobe_t      strb
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (!closed[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign outValid  = inValid ? grant : '0;
  assign inReady   = |(grant & outReady);
  assign strb.take = inValid & inReady;
  assign strb.wipe = strb.take & closeAll;
endmodule

// File: rtl/qsplit_top.sv
module qsplit_top
  import qsplit_pkg::*;
#(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*W-1:0] quota,
  input  logic           inValid,
  output logic           inReady,
  input  logic [W-1:0]   inSize,
  output logic [N-1:0]   outValid,
  input  logic [N-1:0]   outReady,
  output logic [W-1:0]   outSize
);
  strobe_t        strb;
  logic [N-1:0]   grant;
  logic [N-1:0]   closed;
  logic           closeAll;
  logic [N*W-1:0] totalsFlat;
  logic           wipePulse;

  assign outSize   = inSize;
  assign wipePulse = strb.wipe;

  qsplit_ctrl #(.N(N)) u_ctrl (
    .inValid (inValid),
    .closed  (closed),
    .outReady(outReady),
    .closeAll(closeAll),
    .grant   (grant),
    .outValid(outValid),
    .inReady (inReady),
    .strb    (strb)
  );

  qsplit_tally #(.N(N), .W(W)) u_tally (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .grant     (grant),
    .inSize    (inSize),
    .quota     (quota),
    .closed    (closed),
    .closeAll  (closeAll),
    .totalsFlat(totalsFlat)
  );
endmodule

// File: rtl/qsplit_check.sv
module qsplit_check #(
  parameter int N = 3,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [N*W-1:0] quota,
  input logic           inValid,
  input logic           inReady,
  input logic [N-1:0]   outValid,
  input logic [N-1:0]   outReady,
  input logic           wipePulse,
  input logic [N*W-1:0] totalsFlat
);
  logic [N-1:0] zeroMask;
  always_comb begin
    for (int i = 0; i < N; i++) zeroMask[i] = (quota[i*W +: W] == '0);
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(outValid)); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> (outValid == '0)); // R8
  AST_ZERO_QUOTA_IDLE: assert property (@(posedge clk) disable iff (rst)
    (outValid & zeroMask) == '0); // R5
  AST_ALL_ZERO_STALL: assert property (@(posedge clk) disable iff (rst)
    (&zeroMask) |-> !inReady); // R6
  AST_READY_FROM_TARGET: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |-> |(outValid & outReady)); // R7
  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wipePulse |=> (totalsFlat == '0)); // R4
endmodule

bind qsplit_top qsplit_check #(.N(N), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .quota     (quota),
  .inValid   (inValid),
  .inReady   (inReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .wipePulse (wipePulse),
  .totalsFlat(totalsFlat)
);

// File: tb/sim_qsplit_top.sv
module sim_qsplit_top;
  localparam int N = 3;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*W-1:0] quota = '0;
  logic           inValid = 1'b0;
  logic           inReady;
  logic [W-1:0]   inSize = '0;
  logic [N-1:0]   outValid;
  logic [N-1:0]   outReady = '1;
  logic [W-1:0]   outSize;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  int mq[N];
  int mt[N];
  int delivered[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  qsplit_top #(.N(N), .W(W)) u0 (
    .clk(clk), .rst(rst), .quota(quota), .inValid(inValid), .inReady(inReady),
    .inSize(inSize), .outValid(outValid), .outReady(outReady), .outSize(outSize)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expSel();
    for (int i = 0; i < N; i++) if (mt[i] < mq[i]) return i;
    return -1;
  endfunction

  task automatic configure(int q0, int q1, int q2);
    @(negedge clk);
    mq[0] = q0; mq[1] = q1; mq[2] = q2;
    for (int i = 0; i < N; i++) begin
      quota[i*W +: W] = W'(mq[i]);
      mt[i] = 0;
      delivered[i] = 0;
    end
    inValid = 1'b0;
    outReady = '1;
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic sendPkt(int size, string req);
    int e;
    bit allC;
    @(negedge clk);
    inValid = 1'b1;
    inSize = W'(size);
    #1;
    e = expSel();
    check(outValid == ((e < 0) ? '0 : N'(1 << e)), req, int'(outValid), (e < 0) ? 0 : (1 << e));
    check(outSize == W'(size), "R8", int'(outSize), size);
    @(posedge clk);
    if (e >= 0) begin
      delivered[e]++;
      mt[e] = (mt[e] + size > MAXV) ? MAXV : mt[e] + size;
      allC = 1;
      for (int i = 0; i < N; i++) if (mt[i] < mq[i]) allC = 0;
      if (allC) for (int i = 0; i < N; i++) mt[i] = 0;
    end
    #1 inValid = 1'b0;
  endtask

  task automatic testReset();
    configure(2, 3, 1);
    @(negedge clk);
    check(outValid == '0, "R9", int'(outValid), 0);
    check(inReady == 1'b1, "R9", int'(inReady), 1);
    sendPkt(1, "R9");
  endtask

  task automatic testRatio();
    configure(4, 2, 1);
    for (int k = 0; k < 14; k++) sendPkt(1, "R1");
    check(delivered[0] == 8, "R10", delivered[0], 8);
    check(delivered[1] == 4, "R10", delivered[1], 4);
    check(delivered[2] == 2, "R10", delivered[2], 2);
  endtask

  task automatic testOvershoot();
    configure(3, 2, 2);
    sendPkt(5, "R3");
    sendPkt(1, "R3");
    sendPkt(1, "R3");
    sendPkt(2, "R4");
    sendPkt(1, "R4");
    sendPkt(4, "R4");
  endtask

  task automatic testZeroPort();
    configure(1, 0, 2);
    for (int k = 0; k < 7; k++) sendPkt(1, "R5");
    check(delivered[1] == 0, "R5", delivered[1], 0);
  endtask

  task automatic testAllZero();
    configure(0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      inValid = 1'b1;
      #1;
      check(inReady == 1'b0, "R6", int'(inReady), 0);
      check(outValid == '0, "R6", int'(outValid), 0);
    end
    @(negedge clk) inValid = 1'b0;
  endtask

  task automatic testBackpressure();
    configure(2, 2, 2);
    @(negedge clk);
    outReady = 3'b110;
    inValid = 1'b1;
    inSize = 8'd2;
    #1;
    check(inReady == 1'b0, "R7", int'(inReady), 0);
    check(outValid == 3'b001, "R7", int'(outValid), 1);
    @(negedge clk);
    #1;
    check(outValid == 3'b001, "R7", int'(outValid), 1);
    inValid = 1'b0;
    outReady = '1;
    sendPkt(2, "R7");
    sendPkt(2, "R7");
  endtask

  task automatic testSaturate();
    configure(255, 1, 1);
    sendPkt(200, "R2");
    sendPkt(200, "R2");
    sendPkt(1, "R2");
    @(negedge clk);
    check(outValid == '0, "R8", int'(outValid), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    testReset();
    testRatio();
    testOvershoot();
    testZeroPort();
    testAllZero();
    testBackpressure();
    testSaturate();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule